// File: doc/BRIEF.md
# Per-Plane Video Guard Band Clamp

This block sits in a pixel stream and holds every color plane of every pixel inside its own window, bounded by a lower and an upper guard value. A sample above the plane's upper guard leaves as the upper guard. A sample below the lower guard leaves as the lower guard. Any other sample passes unchanged. The guards are treated as unsigned codes. When a build option asks for it, a two's-complement input is moved into the unsigned range before the comparison. A second, separate option moves the clamped result back into two's complement at the output. One instance can take the first option or the second, but not both. Two instances placed around a block that works only on unsigned data give signed handling on both sides of it.

The stream uses a valid/ready handshake and carries two sideband bits, start-of-frame and end-of-line. Both bits travel through the single register stage beside the pixel. With run-time control built in, a small write/read register port sets the enable bit and the guard pairs. A new setting is held pending and only takes effect at the next accepted start-of-frame pixel, so one frame is always processed with one set of limits. Without run-time control, the guards are build parameters and clamping is always on.

Top module: `guard_band_clamp`

## Requirements
- R1: With clamping active, output plane p equals the upper guard of p when the sample is above it, the lower guard of p when the sample is below it, and the sample otherwise. Each plane uses only its own guard pair. Plane p occupies data bits [p*BPS +: BPS].
- R2: When a plane's lower guard is greater than its upper guard, that plane's output is the upper guard whatever the sample value.
- R3: Register map. Address 0 bit 0 is the clamp enable, reset value 1. Address 2p+1 is the lower guard of plane p, reset value 0. Address 2p+2 is the upper guard of plane p, reset value all ones. Reading returns the last written (pending) value. Any other address reads 0 and ignores writes.
- R4: A written enable or guard value first applies to the next accepted pixel whose start-of-frame bit is set, and to that pixel itself. Pixels accepted before it use the earlier values.
- R5: With the active enable at 0, each plane passes through unchanged apart from any sign conversion.
- R6: With SIGNED_IN set, 2^(BPS-1) is added (modulo 2^BPS) to each sample before clamping.
- R7: With SIGNED_OUT set, 2^(BPS-1) is subtracted (modulo 2^BPS) from each clamped plane.
- R8: A configuration with both SIGNED_IN and SIGNED_OUT set fails at elaboration.
- R9: With RUNTIME_CFG cleared, writes have no effect, the guards are LOW_DEF and HIGH_DEF on every plane, the enable reads as 1, and reads return these fixed values.
- R10: A pixel accepted at a clock edge appears at the output after that edge, one cycle of latency. Its start-of-frame and end-of-line bits are unchanged and stay aligned with it.
- R11: While out_valid is high and out_ready is low, the output data and sideband hold steady and in_ready is low. in_ready is high whenever the output stage is empty or out_ready is high.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address, used for both reads and writes |
| reg_wdata | input | BPS | Write data |
| reg_rdata | output | BPS | Pending value at reg_addr (combinational read) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_data | input | PLANES*BPS | Input pixel, plane 0 in the low bits |
| in_sof | input | 1 | Input start-of-frame marker |
| in_eol | input | 1 | Input end-of-line marker |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can accept a pixel |
| out_data | output | PLANES*BPS | Clamped pixel |
| out_sof | output | 1 | Delayed start-of-frame marker |
| out_eol | output | 1 | Delayed end-of-line marker |

## Verification
The active limit set is the hidden state that matters most. If it took a write early, a non-start-of-frame pixel sent right after the write would come out clamped by the new values. If it took the write late, the start-of-frame pixel itself would show the old values. Either fault is visible on the first pixel after the write. A broken output register shows within one cycle of stalling out_ready, as data that moves or an in_ready that stays high. A broken sign offset shows on the first pixel whose MSB changes the order of the comparison.

// File: rtl/gb_pkg.sv
// Shared definitions for the guard band clamp.
// Assumes: consumers pack the sideband with this type.
package gb_pkg;

    // Sideband bits that travel beside each pixel.
    typedef struct packed {
        logic sof;
        logic eol;
    } gb_side_t;

    // Address of the control register; guard pairs follow it.
    localparam int GB_CTRL_ADDR = 0;

endpackage

// File: rtl/gb_regfile.sv
// Guard limit storage: pending values written over the register port, and
// active values that are committed when a start-of-frame pixel is accepted.
// The eff_* outputs already include a commit happening in this cycle.
// Assumes: BPS >= 2; commit is a single-cycle strobe.
module gb_regfile #(
    parameter int PLANES      = 3,
    parameter int BPS         = 8,
    parameter bit RUNTIME_CFG = 1'b1,
    parameter int LOW_DEF     = 0,
    parameter int HIGH_DEF    = 255,
    parameter int ADDR_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BPS-1:0]        wdata,
    output logic [BPS-1:0]        rdata,
    input  logic                  commit,
    output logic [PLANES*BPS-1:0] eff_lo,
    output logic [PLANES*BPS-1:0] eff_hi,
    output logic                  eff_en,
    output logic [PLANES*BPS-1:0] act_lo,
    output logic [PLANES*BPS-1:0] act_hi,
    output logic                  act_en
);
    import gb_pkg::*;

    logic [BPS-1:0] pend_lo [PLANES];
    logic [BPS-1:0] pend_hi [PLANES];
    logic           pend_en;

    generate
        if (RUNTIME_CFG) begin : g_rt
            logic [BPS-1:0] cur_lo [PLANES];
            logic [BPS-1:0] cur_hi [PLANES];
            logic           cur_en;

            // Store register writes as pending values.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_en <= 1'b1;
                    for (int p = 0; p < PLANES; p++) begin
                        pend_lo[p] <= '0;
                        pend_hi[p] <= '1;
                    end
                end else if (wr_en) begin
                    if (addr == ADDR_W'(GB_CTRL_ADDR)) pend_en <= wdata[0];
                    for (int p = 0; p < PLANES; p++) begin
                        if (addr == ADDR_W'(2*p+1)) pend_lo[p] <= wdata;
                        if (addr == ADDR_W'(2*p+2)) pend_hi[p] <= wdata;
                    end
                end
            end

            // Copy pending values to the active set at a frame start.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cur_en <= 1'b1;
                    for (int p = 0; p < PLANES; p++) begin
                        cur_lo[p] <= '0;
                        cur_hi[p] <= '1;
                    end
                end else if (commit) begin
                    cur_en <= pend_en;
                    for (int p = 0; p < PLANES; p++) begin
                        cur_lo[p] <= pend_lo[p];
                        cur_hi[p] <= pend_hi[p];
                    end
                end
            end

            for (genvar p = 0; p < PLANES; p++) begin : g_flat
                assign act_lo[p*BPS +: BPS] = cur_lo[p];
                assign act_hi[p*BPS +: BPS] = cur_hi[p];
                assign eff_lo[p*BPS +: BPS] = commit ? pend_lo[p] : cur_lo[p];
                assign eff_hi[p*BPS +: BPS] = commit ? pend_hi[p] : cur_hi[p];
            end
            assign act_en = cur_en;
            assign eff_en = commit ? pend_en : cur_en;
        end else begin : g_fixed
            localparam logic [BPS-1:0] LO_C = BPS'(LOW_DEF);
            localparam logic [BPS-1:0] HI_C = BPS'(HIGH_DEF);
            for (genvar p = 0; p < PLANES; p++) begin : g_flat
                assign pend_lo[p] = LO_C;
                assign pend_hi[p] = HI_C;
                assign act_lo[p*BPS +: BPS] = LO_C;
                assign act_hi[p*BPS +: BPS] = HI_C;
                assign eff_lo[p*BPS +: BPS] = LO_C;
                assign eff_hi[p*BPS +: BPS] = HI_C;
            end
            assign pend_en = 1'b1;
            assign act_en  = 1'b1;
            assign eff_en  = 1'b1;
        end
    endgenerate

    // Read mux over the pending values.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(GB_CTRL_ADDR)) rdata[0] = pend_en;
        for (int p = 0; p < PLANES; p++) begin
            if (addr == ADDR_W'(2*p+1)) rdata = pend_lo[p];
            if (addr == ADDR_W'(2*p+2)) rdata = pend_hi[p];
        end
    end

endmodule

// File: rtl/gb_plane_clamp.sv
// One plane: optional signed-to-unsigned offset, clamp with the upper guard
// taking priority, then an optional unsigned-to-signed offset.
// Assumes: purely combinational; lo and hi are unsigned codes.
module gb_plane_clamp #(
    parameter int BPS        = 8,
    parameter bit SIGNED_IN  = 1'b0,
    parameter bit SIGNED_OUT = 1'b0
) (
    input  logic [BPS-1:0] x,
    input  logic [BPS-1:0] lo,
    input  logic [BPS-1:0] hi,
    input  logic           en,
    output logic [BPS-1:0] y
);
    localparam logic [BPS-1:0] HALF = BPS'(1) << (BPS-1);

    logic [BPS-1:0] u;
    logic [BPS-1:0] c;

    // Move the sample into the unsigned range if needed.
    always_comb u = SIGNED_IN ? (x + HALF) : x;

    // Clamp; an inverted window collapses onto the upper guard.
    always_comb begin
        c = u;
        if (en) begin
            if ((u > hi) || (lo > hi)) c = hi;
            else if (u < lo)           c = lo;
        end
    end

    // Move the result back to two's complement if needed.
    always_comb y = SIGNED_OUT ? (c - HALF) : c;

endmodule

// File: rtl/gb_pipe_stage.sv
// Single register slice with valid/ready flow control.
// Assumes: upstream holds its data while in_ready is low.
module gb_pipe_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    assign in_ready = out_ready || !out_valid;

    // Load on free slot, hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end

endmodule

// File: rtl/guard_band_clamp.sv
// Top: clamps each plane of a pixel stream to per-plane guard limits,
// with optional sign offsets and frame-aligned limit updates.
// Assumes: SIGNED_IN and SIGNED_OUT are not both set; BPS >= 2.
module guard_band_clamp #(
    parameter int  PLANES      = 3,
    parameter int  BPS         = 8,
    parameter bit  RUNTIME_CFG = 1'b1,
    parameter bit  SIGNED_IN   = 1'b0,
    parameter bit  SIGNED_OUT  = 1'b0,
    parameter int  LOW_DEF     = 0,
    parameter int  HIGH_DEF    = 255,
    localparam int ADDR_W      = $clog2(2*PLANES+1),
    localparam int DW          = PLANES*BPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BPS-1:0]    reg_wdata,
    output logic [BPS-1:0]    reg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DW-1:0]     in_data,
    input  logic              in_sof,
    input  logic              in_eol,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DW-1:0]     out_data,
    output logic              out_sof,
    output logic              out_eol
);
    import gb_pkg::*;

    // R8: reject the combination of both sign options.
    generate
        if (SIGNED_IN && SIGNED_OUT) begin : g_bad_cfg
            $error("guard_band_clamp: SIGNED_IN and SIGNED_OUT are exclusive");
        end
    endgenerate

    logic            commit;
    logic [DW-1:0]   eff_lo, eff_hi, act_lo, act_hi;
    logic            eff_en, act_en;
    logic [DW-1:0]   clamped;
    gb_side_t        side_in, side_out;
    logic [DW+1:0]   stage_out;

    assign commit = in_valid && in_ready && in_sof;

    gb_regfile #(
        .PLANES(PLANES), .BPS(BPS), .RUNTIME_CFG(RUNTIME_CFG),
        .LOW_DEF(LOW_DEF), .HIGH_DEF(HIGH_DEF), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .commit(commit),
        .eff_lo(eff_lo), .eff_hi(eff_hi), .eff_en(eff_en),
        .act_lo(act_lo), .act_hi(act_hi), .act_en(act_en)
    );

    generate
        for (genvar p = 0; p < PLANES; p++) begin : g_plane
            gb_plane_clamp #(
                .BPS(BPS), .SIGNED_IN(SIGNED_IN), .SIGNED_OUT(SIGNED_OUT)
            ) u_clamp (
                .x(in_data[p*BPS +: BPS]),
                .lo(eff_lo[p*BPS +: BPS]),
                .hi(eff_hi[p*BPS +: BPS]),
                .en(eff_en),
                .y(clamped[p*BPS +: BPS])
            );
        end
    endgenerate

    assign side_in = '{sof: in_sof, eol: in_eol};

    gb_pipe_stage #(.W(DW+2)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_data({side_in, clamped}),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(stage_out)
    );

    assign side_out = stage_out[DW+1:DW];
    assign out_data = stage_out[DW-1:0];
    assign out_sof  = side_out.sof;
    assign out_eol  = side_out.eol;

endmodule

// File: rtl/gb_checker.sv
// Temporal checks on the guard band clamp, bound into every instance.
// Assumes: act_* are the limits that governed the beat now in the output stage.
module gb_checker #(
    parameter int PLANES     = 3,
    parameter int BPS        = 8,
    parameter bit SIGNED_OUT = 1'b0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [PLANES*BPS-1:0] out_data,
    input logic                  out_sof,
    input logic                  out_eol,
    input logic [PLANES*BPS-1:0] act_lo,
    input logic [PLANES*BPS-1:0] act_hi,
    input logic                  act_en
);
    // R11
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sof) && $stable(out_eol)));

    // R11
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R11
    empty_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R10
    one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    generate
        if (!SIGNED_OUT) begin : g_bounds
            for (genvar p = 0; p < PLANES; p++) begin : g_p
                // R1
                upper_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (out_valid && act_en) |->
                    (out_data[p*BPS +: BPS] <= act_hi[p*BPS +: BPS]));
                // R1
                lower_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (out_valid && act_en &&
                     (act_lo[p*BPS +: BPS] <= act_hi[p*BPS +: BPS])) |->
                    (out_data[p*BPS +: BPS] >= act_lo[p*BPS +: BPS]));
                // R2
                inverted_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (out_valid && act_en &&
                     (act_lo[p*BPS +: BPS] > act_hi[p*BPS +: BPS])) |->
                    (out_data[p*BPS +: BPS] == act_hi[p*BPS +: BPS]));
            end
        end
    endgenerate

endmodule

bind guard_band_clamp gb_checker #(
    .PLANES(PLANES), .BPS(BPS), .SIGNED_OUT(SIGNED_OUT)
) u_gb_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol),
    .act_lo(act_lo), .act_hi(act_hi), .act_en(act_en)
);

// File: tb/tb_guard_band_clamp.sv
// Bench: one run-time instance plus two fixed instances (signed in, signed out)
// on a shared stimulus. Inputs change on the falling edge; outputs are read there.
module tb_guard_band_clamp;
    localparam int PL = 3;
    localparam int B  = 8;
    localparam int AW = $clog2(2*PL+1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [B-1:0]  wdata = '0;
    logic          in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [PL*B-1:0] in_data = '0;
    logic          out_ready = 1'b1;

    logic [B-1:0]    rd_a, rd_b, rd_c;
    logic            rdy_a, rdy_b, rdy_c, ov_a, ov_b, ov_c;
    logic [PL*B-1:0] od_a, od_b, od_c;
    logic            os_a, os_b, os_c, oe_a, oe_b, oe_c;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;  // 50 MHz

    guard_band_clamp #(.PLANES(PL), .BPS(B), .RUNTIME_CFG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd_a), .in_valid(in_valid),
        .in_ready(rdy_a), .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(ov_a), .out_ready(out_ready), .out_data(od_a),
        .out_sof(os_a), .out_eol(oe_a));

    guard_band_clamp #(.PLANES(PL), .BPS(B), .RUNTIME_CFG(1'b0), .SIGNED_IN(1'b1),
                       .LOW_DEF(16), .HIGH_DEF(235)) dut_sin (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd_b), .in_valid(in_valid),
        .in_ready(rdy_b), .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(ov_b), .out_ready(out_ready), .out_data(od_b),
        .out_sof(os_b), .out_eol(oe_b));

    guard_band_clamp #(.PLANES(PL), .BPS(B), .RUNTIME_CFG(1'b0), .SIGNED_OUT(1'b1),
                       .LOW_DEF(16), .HIGH_DEF(235)) dut_sout (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd_c), .in_valid(in_valid),
        .in_ready(rdy_c), .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(ov_c), .out_ready(out_ready), .out_data(od_c),
        .out_sof(os_c), .out_eol(oe_c));

    // Stimulus table: {sof, eol, pixel}, plus expected run-time output.
    localparam int NV = 6;
    localparam logic [25:0] VEC_IN [NV] = '{
        {2'b10, 24'h000000}, {2'b00, 24'hFFFFFF}, {2'b00, 24'h808080},
        {2'b00, 24'h1020EB}, {2'b01, 24'h64C90F}, {2'b00, 24'h331FEC}};
    localparam logic [23:0] VEC_EXP [NV] = '{
        24'h322010, 24'h32C8EB, 24'h328080, 24'h3220EB, 24'h32C810, 24'h3220EB};

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference for one fixed-limit plane, written from R1, R6 and R7.
    function automatic logic [7:0] ref_fixed(input logic [7:0] x, input bit sin, input bit sout);
        logic [7:0] v;
        v = sin ? 8'(x + 8'd128) : x;
        if (v > 8'd235) v = 8'd235;
        else if (v < 8'd16) v = 8'd16;
        return sout ? 8'(v - 8'd128) : v;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = B'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Send one beat with out_ready high, then check all three outputs.
    task automatic beat(input logic [23:0] px, input logic s, input logic e,
                        input logic [23:0] exp_a, input string req);
        logic [23:0] eb, ec;
        @(negedge clk);
        in_valid = 1'b1; in_data = px; in_sof = s; in_eol = e;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        for (int p = 0; p < PL; p++) begin
            eb[p*8 +: 8] = ref_fixed(px[p*8 +: 8], 1'b1, 1'b0);
            ec[p*8 +: 8] = ref_fixed(px[p*8 +: 8], 1'b0, 1'b1);
        end
        chk(req, "run-time data", 32'(od_a), 32'(exp_a));
        chk("R10", "valid+sideband", {29'd0, ov_a, os_a, oe_a}, {29'd0, 1'b1, s, e});
        chk("R6", "signed-in data", 32'(od_b), 32'(eb));
        chk("R7", "signed-out data", 32'(od_c), 32'(ec));
    endtask

    initial begin : watchdog
        #(20ns * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12", "out_valid", 32'(ov_a), 32'd0);
        chk("R12", "in_ready", 32'(rdy_a), 32'd1);
        // R3: reset register values
        addr = 0; #1 chk("R3", "enable reset", 32'(rd_a), 32'd1);
        addr = 1; #1 chk("R3", "lo0 reset", 32'(rd_a), 32'd0);
        addr = 2; #1 chk("R3", "hi0 reset", 32'(rd_a), 32'd255);

        // Program limits: p0 [16,235], p1 [32,200], p2 inverted lo=100 hi=50.
        wr(1, 16); wr(2, 235); wr(3, 32); wr(4, 200); wr(5, 100); wr(6, 50);
        addr = 5; #1 chk("R3", "lo2 readback", 32'(rd_a), 32'd100);
        // R9: fixed instance ignores writes and reports its constants
        addr = 1; #1 chk("R9", "fixed lo readback", 32'(rd_b), 32'd16);
        addr = 2; #1 chk("R9", "fixed hi readback", 32'(rd_c), 32'd235);
        addr = 0; #1 chk("R9", "fixed enable", 32'(rd_b), 32'd1);

        // R4: no frame start yet, old limits (0..255) still apply
        beat(24'h05F0FF, 1'b0, 1'b0, 24'h05F0FF, "R4");

        // R1/R2: table walk, first entry opens a frame
        for (int i = 0; i < NV; i++)
            beat(VEC_IN[i][23:0], VEC_IN[i][25], VEC_IN[i][24], VEC_EXP[i], "R1/R2");

        // R5: disable takes effect only at the next frame start
        wr(0, 0);
        beat(24'h000000, 1'b0, 1'b0, 24'h322010, "R4");
        beat(24'hFF00FF, 1'b1, 1'b0, 24'hFF00FF, "R5");
        beat(24'h123456, 1'b0, 1'b1, 24'h123456, "R5");

        // Re-enable with a new plane-2 window [40,60]
        wr(0, 1); wr(5, 40); wr(6, 60);
        beat(24'h00FF50, 1'b1, 1'b0, 24'h28C850, "R4");

        // R11: backpressure
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_data = 24'h000000; in_eol = 1'b1;
        @(negedge clk);
        in_data = 24'hFFFFFF; in_eol = 1'b0;
        chk("R11", "in_ready under stall", 32'(rdy_a), 32'd0);
        repeat (3) @(negedge clk);
        chk("R11", "held data", 32'(od_a), 32'h282010);
        chk("R11", "held eol", {30'd0, ov_a, oe_a}, 32'd3);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11", "next beat after release", 32'(od_a), 32'h3CC8EB);
        chk("R10", "next beat sideband", 32'(oe_a), 32'd0);
        @(negedge clk);
        chk("R11", "drained", 32'(ov_a), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule